// File: doc/BRIEF.md
# Paged Address Translator with Recency-Ordered Frame Reclaim

This block turns an 8-bit byte virtual address into a 7-bit physical address. The upper four bits select one of sixteen virtual pages and the lower four bits are the offset within a 16-byte page. Physical storage holds eight 16-byte frames. One of them is reserved for the page table, and that table holds one entry per virtual page. A small fully associative translation cache with three slots sits in front of the table.

Each accepted request resolves in one clock edge, and the answer appears on the following cycle. A cached mapping gives a hit. A mapping found only in the table refills the cache. A page with no frame raises a fault: the page is given a free frame, or failing that the least recently touched frame, and its new mapping goes into both the table and the cache. Moving page data is outside this block. The fault flag tells the surrounding logic that a fill happened.

Top module: `xlate_unit`

## Requirements
- R1: After reset the translation cache, the page table and every frame except the table frame are empty, no response is signalled, and the first access to any page reports a fault.
- R2: A request presented on a clock edge yields `respValid` high on the next cycle, with `respPaddr` equal to {frame number, request offset}, where the offset is bits [3:0] of the virtual address and the frame number occupies bits [6:4].
- R3: When the page (address bits [7:4]) is held in the translation cache, the response has `respHit`=1 and `respFault`=0. Hit and fault are never both high.
- R4: When the page is absent from the cache but mapped in the table, the response has `respHit`=0 and `respFault`=0, and the mapping is loaded into the cache.
- R5: The cache holds three mappings. A refill takes the lowest-numbered empty slot, or otherwise the slot least recently used. A hit makes its slot the most recently used, so a page accessed twice in a row hits the second time.
- R6: A page with no frame gives `respHit`=0 and `respFault`=1. It is placed in the lowest-numbered empty frame, and its mapping enters the table and the cache.
- R7: When no frame is empty, a fault reclaims the least recently used resident frame. Every access refreshes the recency of the frame it resolves to, whether it hits in the cache, refills the cache or faults.
- R8: Frame 0 holds the page table and is never handed to a page, so no response carries frame number 0.
- R9: When a frame is reclaimed, the former page's table entry and any cache slot holding it become invalid, and the next access to that page faults.
- R10: A cycle with `reqValid` low changes no state, and on the next cycle `respValid`, `respHit` and `respFault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translate request strobe |
| reqVaddr | input | 8 | Virtual byte address of the request |
| respValid | output | 1 | Response present for the previous cycle's request |
| respPaddr | output | 7 | Translated physical byte address |
| respHit | output | 1 | Mapping was found in the translation cache |
| respFault | output | 1 | Page had no frame and was just given one |

## Verification
A directed reference string over a dozen pages first fills the free frames in order. It then forces cache-slot and frame reclaim, which separates cache recency from frame recency. A page kept recent only through cache hits must survive frame reclaim, and that shows whether hits refresh frame order. A thrash over ten pages checks that reclaimed pages fault again and that their stale cache slots are not reused as hits. Random addresses with random idle cycles, checked against a timestamp model of both LRU orders, cover the mixed hit, refill and fault paths and show that idle cycles change no state.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Strobes issued by control to the datapath for the current request
  typedef struct packed {
    logic touch;    // a request is being served: refresh recency, respond
    logic tlbFill;  // write the resolved mapping into a cache slot
    logic install;  // assign a frame to the page and update the table
    logic hit;      // response flag: cache hit
    logic fault;    // response flag: page fault
  } xlateStrobe_t;
endpackage

// File: rtl/xlate_lru.sv
// Recency ranks (0 = most recent) with a victim picker that prefers
// empty candidates at the lowest index, else the oldest candidate.
module xlate_lru #(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touchEn,
  input  logic [IDX_W-1:0] touchIdx,
  input  logic [N-1:0]     candMask,
  input  logic [N-1:0]     freeMask,
  output logic [IDX_W-1:0] victimIdx
);
  logic [IDX_W-1:0] rank [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) rank[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touchIdx) rank[i] <= '0;
        else if (rank[i] < rank[touchIdx]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    logic anyCand;
    logic [IDX_W-1:0] bestRank;
    victimIdx = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (candMask[i] && freeMask[i]) begin
        victimIdx = IDX_W'(i);
        found = 1'b1;
      end
    end
    anyCand = 1'b0;
    bestRank = '0;
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (candMask[i] && (!anyCand || rank[i] > bestRank)) begin
          victimIdx = IDX_W'(i);
          bestRank = rank[i];
          anyCand = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic         reqValid,
  input  logic         tlbHit,
  input  logic         ptHit,
  output xlateStrobe_t strb
);
  always_comb begin
    strb.touch   = reqValid;
    strb.hit     = reqValid && tlbHit;
    strb.tlbFill = reqValid && !tlbHit;
    strb.install = reqValid && !tlbHit && !ptHit;
    strb.fault   = strb.install;
  end
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int VA_W     = 8,
  parameter int OFF_W    = 4,
  parameter int PA_W     = 7,
  parameter int TLB_N    = 3,
  parameter int PT_FRAME = 0,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int NFRM  = 1 << PFN_W,
  localparam int NPG   = 1 << VPN_W,
  localparam int TI_W  = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [VA_W-1:0] reqVaddr,
  input  xlateStrobe_t    strb,
  output logic            tlbHit,
  output logic            ptHit,
  output logic            respValid,
  output logic [PA_W-1:0] respPaddr,
  output logic            respHit,
  output logic            respFault
);
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  assign vpn = reqVaddr[VA_W-1:OFF_W];
  assign off = reqVaddr[OFF_W-1:0];

  logic [TLB_N-1:0] tlbV;
  logic [VPN_W-1:0] tlbVpn [TLB_N];
  logic [PFN_W-1:0] tlbPfn [TLB_N];
  logic [NPG-1:0]   ptV;
  logic [PFN_W-1:0] ptPfn [NPG];
  logic [NFRM-1:0]  frmUsed;
  logic [VPN_W-1:0] frmVpn [NFRM];

  logic [TLB_N-1:0] tlbMatch, staleMatch;
  logic [TI_W-1:0]  hitIdx, staleIdx, tlbLruVictim, slotSel;
  logic [PFN_W-1:0] hitPfn, frmVictim, pfnSel;
  logic             evicting;
  logic [VPN_W-1:0] oldVpn;

  assign evicting = frmUsed[frmVictim];
  assign oldVpn   = frmVpn[frmVictim];

  for (genvar g = 0; g < TLB_N; g++) begin : gSlot
    assign tlbMatch[g]   = tlbV[g] && (tlbVpn[g] == vpn);
    assign staleMatch[g] = tlbV[g] && (tlbVpn[g] == oldVpn) && evicting && strb.install;
  end

  always_comb begin
    hitIdx = '0;
    hitPfn = '0;
    staleIdx = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (tlbMatch[i]) begin
        hitIdx = TI_W'(i);
        hitPfn = tlbPfn[i];
      end
      if (staleMatch[i]) staleIdx = TI_W'(i);
    end
  end

  assign tlbHit  = |tlbMatch;
  assign ptHit   = ptV[vpn];
  assign slotSel = tlbHit ? hitIdx : (|staleMatch ? staleIdx : tlbLruVictim);
  assign pfnSel  = tlbHit ? hitPfn : (ptHit ? ptPfn[vpn] : frmVictim);

  xlate_lru #(.N(NFRM)) u_frmLru (
    .clk(clk), .rstN(rstN), .touchEn(strb.touch), .touchIdx(pfnSel),
    .candMask(~(NFRM'(1) << PT_FRAME)), .freeMask(~frmUsed),
    .victimIdx(frmVictim)
  );

  xlate_lru #(.N(TLB_N)) u_tlbLru (
    .clk(clk), .rstN(rstN), .touchEn(strb.touch), .touchIdx(slotSel),
    .candMask({TLB_N{1'b1}}), .freeMask(~tlbV),
    .victimIdx(tlbLruVictim)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbV      <= '0;
      ptV       <= '0;
      frmUsed   <= '0;
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFault <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= strb.touch;
      respHit   <= strb.hit;
      respFault <= strb.fault;
      if (strb.touch) respPaddr <= {pfnSel, off};
      if (strb.install) begin
        if (evicting) ptV[oldVpn] <= 1'b0;
        ptV[vpn]            <= 1'b1;
        frmUsed[frmVictim]  <= 1'b1;
      end
      if (strb.tlbFill) tlbV[slotSel] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.install) begin
      ptPfn[vpn]        <= frmVictim;
      frmVpn[frmVictim] <= vpn;
    end
    if (strb.tlbFill) begin
      tlbVpn[slotSel] <= vpn;
      tlbPfn[slotSel] <= pfnSel;
    end
  end
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W     = 8,
  parameter int OFF_W    = 4,
  parameter int PA_W     = 7,
  parameter int TLB_N    = 3,
  parameter int PT_FRAME = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqVaddr,
  output logic            respValid,
  output logic [PA_W-1:0] respPaddr,
  output logic            respHit,
  output logic            respFault
);
  xlateStrobe_t strb;
  logic tlbHit, ptHit;

  xlate_ctrl u_ctrl (
    .reqValid(reqValid), .tlbHit(tlbHit), .ptHit(ptHit), .strb(strb)
  );

  xlate_dp #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .TLB_N(TLB_N), .PT_FRAME(PT_FRAME)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqVaddr(reqVaddr), .strb(strb),
    .tlbHit(tlbHit), .ptHit(ptHit), .respValid(respValid),
    .respPaddr(respPaddr), .respHit(respHit), .respFault(respFault)
  );
endmodule

// File: rtl/xlate_unit_chk.sv
module xlate_unit_chk #(
  parameter int VA_W     = 8,
  parameter int OFF_W    = 4,
  parameter int PA_W     = 7,
  parameter int PT_FRAME = 0
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVaddr,
  input logic            respValid,
  input logic [PA_W-1:0] respPaddr,
  input logic            respHit,
  input logic            respFault
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])); // R2
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !(respHit && respFault)); // R3
  AST_REPEAT_HITS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && respValid && reqVaddr[VA_W-1:OFF_W] == $past(reqVaddr[VA_W-1:OFF_W]))
      |=> respHit); // R5
  AST_TABLE_FRAME_PINNED: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> respPaddr[PA_W-1:OFF_W] != (PA_W-OFF_W)'(PT_FRAME)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid && !respHit && !respFault); // R10
endmodule

bind xlate_unit xlate_unit_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .PT_FRAME(PT_FRAME)
) u_chk (.*);

// File: tb/xlate_unit_tb.sv
`timescale 1ns/1ps
module xlate_unit_tb;
  localparam int NFRM = 8;
  localparam int NSLOT = 3;
  localparam int PTF = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqVaddr = '0;
  logic respValid, respHit, respFault;
  logic [6:0] respPaddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlate_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .respValid(respValid), .respPaddr(respPaddr), .respHit(respHit), .respFault(respFault)
  );

  // Reference model: timestamps of last use for both recency orders
  bit mUsed [NFRM];
  int mFVpn [NFRM];
  int mFT   [NFRM];
  bit mPtV  [16];
  int mPtF  [16];
  bit mTV   [NSLOT];
  int mTVpn [NSLOT];
  int mTPfn [NSLOT];
  int mTT   [NSLOT];
  int now;

  function automatic void modelReset();
    for (int i = 0; i < NFRM; i++) begin mUsed[i] = 0; mFVpn[i] = 0; mFT[i] = 0; end
    for (int i = 0; i < 16; i++) begin mPtV[i] = 0; mPtF[i] = 0; end
    for (int i = 0; i < NSLOT; i++) begin mTV[i] = 0; mTVpn[i] = 0; mTPfn[i] = 0; mTT[i] = 0; end
    now = 0;
  endfunction

  function automatic void modelFill(int vpn, int pfn);
    int s = -1;
    for (int i = 0; i < NSLOT; i++) if (!mTV[i] && s < 0) s = i;
    if (s < 0) begin
      s = 0;
      for (int i = 1; i < NSLOT; i++) if (mTT[i] < mTT[s]) s = i;
    end
    mTV[s] = 1; mTVpn[s] = vpn; mTPfn[s] = pfn; mTT[s] = now;
  endfunction

  function automatic void modelAccess(int va, output bit eHit, output bit eFault,
                                      output bit eEvict, output int ePa);
    int vpn = va >> 4;
    int pfn = -1;
    now++;
    eHit = 0; eFault = 0; eEvict = 0;
    for (int i = 0; i < NSLOT; i++)
      if (mTV[i] && mTVpn[i] == vpn) begin pfn = mTPfn[i]; mTT[i] = now; eHit = 1; end
    if (!eHit) begin
      if (mPtV[vpn]) pfn = mPtF[vpn];
      else begin
        eFault = 1;
        for (int f = 0; f < NFRM; f++) if (f != PTF && !mUsed[f] && pfn < 0) pfn = f;
        if (pfn < 0) begin
          for (int f = 0; f < NFRM; f++)
            if (f != PTF && (pfn < 0 || mFT[f] < mFT[pfn])) pfn = f;
          eEvict = 1;
          mPtV[mFVpn[pfn]] = 0;
          for (int i = 0; i < NSLOT; i++) if (mTV[i] && mTVpn[i] == mFVpn[pfn]) mTV[i] = 0;
        end
        mUsed[pfn] = 1; mFVpn[pfn] = vpn; mPtV[vpn] = 1; mPtF[vpn] = pfn;
      end
      modelFill(vpn, pfn);
    end
    mFT[pfn] = now;
    ePa = (pfn << 4) | (va & 15);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  string phase = "";

  // Called right after a falling edge; checks the response at the next one
  task automatic step(bit v, int va);
    bit eHit, eFault, eEvict;
    int ePa;
    string tag;
    eHit = 0; eFault = 0; eEvict = 0; ePa = 0;
    reqValid = v;
    reqVaddr = 8'(va);
    if (v) modelAccess(va, eHit, eFault, eEvict, ePa);
    @(negedge clk);
    if (!v) begin
      chk({phase, "R10"}, "respValid idle", int'(respValid), 0);
      chk({phase, "R10"}, "flags idle", int'(respHit) + int'(respFault), 0);
    end else begin
      tag = eHit ? "R3 R5" : (eFault ? (eEvict ? "R6 R7 R9" : "R6 R8") : "R4 R5");
      chk({phase, "R2"}, "respValid", int'(respValid), 1);
      chk({phase, tag}, "respHit", int'(respHit), int'(eHit));
      chk({phase, tag}, "respFault", int'(respFault), int'(eFault));
      chk({phase, "R2 R7"}, "respPaddr", int'(respPaddr), ePa);
    end
  endtask

  task automatic doReset();
    reqValid = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    @(negedge clk);
    chk("R1", "respValid after reset", int'(respValid), 0);
  endtask

  initial begin
    int refs [16] = '{0, 13, 5, 2, 14, 14, 13, 6, 6, 13, 15, 14, 15, 13, 4, 3};
    void'($urandom(32'h1c0ffee5));
    doReset();
    phase = "R1 ";
    step(1, 8'h37);                           // first access must fault
    phase = "";
    doReset();

    // Directed reference string with mixed offsets
    foreach (refs[i]) step(1, refs[i] * 16 + (i % 16));
    // Keep page 13 recent through cache hits only, then force reclaim (R7)
    step(1, 13 * 16 + 1);
    for (int p = 7; p < 12; p++) begin
      step(1, p * 16 + 2);
      step(1, 13 * 16 + 3);
    end
    // Idle cycles change nothing (R10)
    step(0, 8'hff);
    step(0, 8'h00);
    // Thrash ten pages twice: reclaimed pages fault again (R9)
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < 10; p++) step(1, p * 16 + p);
    // Same page back to back hits (R5)
    step(1, 8'h9a);
    step(1, 8'h9b);

    // Random traffic with idle gaps
    for (int n = 0; n < 600; n++) begin
      bit v = ($urandom % 4) != 0;
      int va = (n % 3 == 0) ? int'($urandom % 64) : int'($urandom % 256);
      step(v, va);
    end

    reqValid = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule